// File: doc/BRIEF.md
# Bridge Interrupt Propagation Controller

This block sits on the memory-mapped side of a PCI Express endpoint bridge. It collects eight software mailbox interrupts and one level-sensitive interrupt from local components. From them it produces link-level interrupt requests for the transaction layer. Each mailbox source latches into a status register that can be read and written, and a matching enable register masks it. The local interrupt is not latched: its status bit always shows the live input, and only the component that raised it can clear it.

The enabled mailbox bits and the local input are combined into one interrupt, which is held in a flop. Two configuration inputs decide, cycle by cycle, how a change of that interrupt leaves the block. With message signalling enabled, a rising edge becomes a single-cycle MSI request. Otherwise, if legacy interrupts are not disabled, the block tracks the virtual INTA wire. A rising edge becomes an assert request, and a fall becomes a deassert request. If the mode changes while the wire is asserted, the block releases the wire.

Top module: `irq_prop_ctrl`

## Requirements
- R1: While reset is low, status, enable and interrupt state are cleared, all three request outputs are 0, and reads of 0x040 and 0x050 return 0.
- R2: A one on mbox_set[i] at a clock edge sets status bit i. The status register reads at offset 0x040, with mailbox bits in positions 7:0.
- R3: A write to 0x040 clears every mailbox bit whose data bit is 1. Bits written 0 keep their value.
- R4: When a mailbox set and a write-one clear of the same bit meet at the same edge, the bit ends up set.
- R5: The enable register reads and writes at 0x050, bits 7:0. A set mailbox bit adds to the combined interrupt only while its enable bit is 1.
- R6: Bit 16 of a read at 0x040 shows local_irq in the same cycle. Writes do not change it, and local_irq always adds to the combined interrupt.
- R7: With cfg_msi_en=1, a rising combined interrupt gives msi_req high for exactly one cycle, and no INTA request is issued. The rising interrupt is the first cycle it is high after a low cycle, and msi_req is high in the next cycle.
- R8: With cfg_msi_en=0 and cfg_intx_dis=0, a rising combined interrupt gives a one-cycle inta_assert, and a fall gives a one-cycle inta_deassert. Each comes in the cycle after the change.
- R9: With cfg_msi_en=0 and cfg_intx_dis=1, no request of any kind is issued.
- R10: If cfg_msi_en rises or cfg_intx_dis rises while INTA is asserted, a one-cycle inta_deassert is issued in the next cycle.
- R11: A new source that arrives while the combined interrupt is already high issues no further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mbox_set | input | 8 | Per-bit mailbox set events |
| local_irq | input | 1 | Level interrupt from local components |
| cfg_msi_en | input | 1 | MSI enable configuration bit |
| cfg_intx_dis | input | 1 | Legacy interrupt disable configuration bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| msi_req | output | 1 | One-cycle MSI request |
| inta_assert | output | 1 | One-cycle assert-INTA message request |
| inta_deassert | output | 1 | One-cycle deassert-INTA message request |

## Verification
Two pairs of functions can meet in the same cycle. The first is a mailbox set event and a software write-one clear of the same status bit. The bench drives both in one cycle, then reads the status register to confirm the set survived. The second is a mode change while the INTA wire is asserted. The bench raises cfg_intx_dis or cfg_msi_en with an interrupt pending and expects exactly one deassert and no MSI. A behavioural model built from integer state judges every cycle against the outputs and the read data.

// File: rtl/irq_prop_ctrl.sv
module irq_prop_ctrl #(
  parameter int NUM_MBOX  = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int LOCAL_BIT = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h040,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 'h050
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_MBOX-1:0] mbox_set,
  input  logic                local_irq,
  input  logic                cfg_msi_en,
  input  logic                cfg_intx_dis,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                msi_req,
  output logic                inta_assert,
  output logic                inta_deassert
);

  logic [NUM_MBOX-1:0] stat_q, en_q;
  logic                irq_q, inta_on_q;

  wire wr_stat = reg_wr && (reg_addr == STAT_ADDR);
  wire wr_en   = reg_wr && (reg_addr == EN_ADDR);
  wire [NUM_MBOX-1:0] clr = wr_stat ? reg_wdata[NUM_MBOX-1:0] : '0;

  wire irq_any   = (|(stat_q & en_q)) | local_irq;
  wire legacy_ok = !cfg_msi_en && !cfg_intx_dis;
  wire irq_rise  = irq_any && !irq_q;
  wire drop      = inta_on_q && (!irq_any || !legacy_ok);

  wire unused_wdata = ^reg_wdata[DATA_W-1:NUM_MBOX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q        <= '0;
      en_q          <= '0;
      irq_q         <= 1'b0;
      inta_on_q     <= 1'b0;
      msi_req       <= 1'b0;
      inta_assert   <= 1'b0;
      inta_deassert <= 1'b0;
    end else begin
      stat_q        <= (stat_q & ~clr) | mbox_set;
      if (wr_en) en_q <= reg_wdata[NUM_MBOX-1:0];
      irq_q         <= irq_any;
      msi_req       <= irq_rise && cfg_msi_en;
      inta_assert   <= irq_rise && legacy_ok;
      inta_deassert <= drop;
      if (irq_rise && legacy_ok) inta_on_q <= 1'b1;
      else if (drop)             inta_on_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STAT_ADDR) begin
      reg_rdata[NUM_MBOX-1:0] = stat_q;
      reg_rdata[LOCAL_BIT]    = local_irq;
    end else if (reg_addr == EN_ADDR) begin
      reg_rdata[NUM_MBOX-1:0] = en_q;
    end
  end

endmodule

// File: rtl/irq_prop_ctrl_chk.sv
module irq_prop_ctrl_chk #(
  parameter int NUM_MBOX = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_MBOX-1:0] mbox_set,
  input logic [NUM_MBOX-1:0] stat_q,
  input logic                cfg_msi_en,
  input logic                cfg_intx_dis,
  input logic                msi_req,
  input logic                inta_assert,
  input logic                inta_deassert
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!msi_req && !inta_assert && !inta_deassert)); // R1
  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n) (|mbox_set) |=> ((stat_q & $past(mbox_set)) == $past(mbox_set))); // R4
  AST_MSI_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) msi_req |-> (!inta_assert && !inta_deassert)); // R7
  AST_MSI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) msi_req |=> !msi_req); // R7
  AST_ASSERT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) inta_assert |=> !inta_assert); // R8
  AST_ASSERT_GATED: assert property (@(posedge clk) disable iff (!rst_n) inta_assert |-> $past(!cfg_msi_en && !cfg_intx_dis)); // R9
  AST_NO_DUAL_WIRE: assert property (@(posedge clk) disable iff (!rst_n) !(inta_assert && inta_deassert)); // R10

endmodule

bind irq_prop_ctrl irq_prop_ctrl_chk #(.NUM_MBOX(NUM_MBOX)) u_chk (
  .clk(clk), .rst_n(rst_n), .mbox_set(mbox_set), .stat_q(stat_q),
  .cfg_msi_en(cfg_msi_en), .cfg_intx_dis(cfg_intx_dis),
  .msi_req(msi_req), .inta_assert(inta_assert), .inta_deassert(inta_deassert)
);

// File: tb/irq_prop_ctrl_tb.sv
module irq_prop_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mbox_set = '0;
  logic        local_irq = 1'b0, cfg_msi_en = 1'b0, cfg_intx_dis = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msi_req, inta_assert, inta_deassert;

  int checks = 0, fails = 0;
  int n_msi = 0, n_as = 0, n_de = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_prop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mbox_set(mbox_set), .local_irq(local_irq),
    .cfg_msi_en(cfg_msi_en), .cfg_intx_dis(cfg_intx_dis), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msi_req(msi_req), .inta_assert(inta_assert), .inta_deassert(inta_deassert)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_stat = 0, m_en = 0;
  bit m_prev = 0, m_on = 0, e_msi = 0, e_as = 0, e_de = 0;

  always @(posedge clk) begin
    bit c, leg;
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_prev = 0; m_on = 0; e_msi = 0; e_as = 0; e_de = 0;
    end else begin
      c   = ((m_stat & m_en) != 0) || local_irq;
      leg = !cfg_msi_en && !cfg_intx_dis;
      e_msi = c && !m_prev && cfg_msi_en;
      e_as  = c && !m_prev && leg;
      e_de  = m_on && (!c || !leg);
      if (e_as) m_on = 1; else if (e_de) m_on = 0;
      m_prev = c;
      if (reg_wr && reg_addr == 12'h040) m_stat = m_stat & ~int'(reg_wdata[7:0]);
      m_stat = m_stat | int'(mbox_set);
      if (reg_wr && reg_addr == 12'h050) m_en = int'(reg_wdata[7:0]);
    end
  end

  always @(negedge clk) begin
    int exp_rd;
    exp_rd = (reg_addr == 12'h040) ? (m_stat | (int'(local_irq) << 16)) :
             (reg_addr == 12'h050) ? m_en : 0;
    check("R7 msi_req per-cycle", int'(msi_req), int'(e_msi));
    check("R8 inta_assert per-cycle", int'(inta_assert), int'(e_as));
    check("R8 inta_deassert per-cycle", int'(inta_deassert), int'(e_de));
    check("R2 read data per-cycle", int'(reg_rdata), exp_rd);
    n_msi += int'(msi_req); n_as += int'(inta_assert); n_de += int'(inta_deassert);
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic setmb(logic [7:0] m);
    @(posedge clk); #1;
    mbox_set = m;
    @(posedge clk); #1;
    mbox_set = '0;
  endtask

  task automatic rd(logic [11:0] a, output int v);
    reg_addr = a; #1;
    v = int'(reg_rdata);
  endtask

  initial begin
    int v, b_msi, b_as, b_de;
    idle(3);
    check("R1 msi_req in reset", int'(msi_req), 0);
    check("R1 inta_assert in reset", int'(inta_assert), 0);
    check("R1 inta_deassert in reset", int'(inta_deassert), 0);
    rd(12'h040, v); check("R1 status reset", v, 0);
    rd(12'h050, v); check("R1 enable reset", v, 0);
    rst_n = 1;
    wr(12'h050, 32'hFF);
    rd(12'h050, v); check("R5 enable readback", v, 32'hFF);

    b_as = n_as;
    setmb(8'h08); idle(3);
    rd(12'h040, v); check("R2 status bit 3", v, 32'h08);
    check("R8 assert on rise", n_as - b_as, 1);

    b_as = n_as;
    setmb(8'h01); idle(3);
    check("R11 no second assert", n_as - b_as, 0);

    wr(12'h040, 32'h01); idle(1);
    rd(12'h040, v); check("R3 write-one clear", v, 32'h08);
    b_de = n_de;
    wr(12'h040, 32'h08); idle(3);
    rd(12'h040, v); check("R3 cleared", v, 0);
    check("R8 deassert on fall", n_de - b_de, 1);

    @(posedge clk); #1;
    reg_wr = 1; reg_addr = 12'h040; reg_wdata = 32'h04; mbox_set = 8'h04;
    @(posedge clk); #1;
    reg_wr = 0; mbox_set = '0;
    rd(12'h040, v); check("R4 set wins over clear", v, 32'h04);
    wr(12'h040, 32'h04); idle(3);

    wr(12'h050, 32'h00);
    b_as = n_as;
    setmb(8'h20); idle(3);
    rd(12'h040, v); check("R5 masked bit latched", v, 32'h20);
    check("R5 masked bit silent", n_as - b_as, 0);
    wr(12'h050, 32'h20); idle(3);
    check("R5 enabling raises", n_as - b_as, 1);
    wr(12'h040, 32'hFF); wr(12'h050, 32'hFF); idle(3);

    b_as = n_as; b_de = n_de;
    local_irq = 1; reg_addr = 12'h040; #1;
    check("R6 local bit same cycle", int'(reg_rdata[16]), 1);
    wr(12'h040, 32'h1_0000); idle(2);
    rd(12'h040, v); check("R6 local bit not writable", v, 32'h1_0000);
    check("R6 local raises assert", n_as - b_as, 1);
    local_irq = 0; idle(3);
    check("R6 local drop deasserts", n_de - b_de, 1);

    cfg_msi_en = 1;
    b_msi = n_msi; b_as = n_as;
    setmb(8'h02); idle(3);
    wr(12'h040, 32'h02); idle(2);
    setmb(8'h02); idle(3);
    check("R7 one msi per edge", n_msi - b_msi, 2);
    check("R7 no inta in msi mode", n_as - b_as, 0);
    wr(12'h040, 32'h02); idle(2);

    cfg_msi_en = 0; cfg_intx_dis = 1;
    b_msi = n_msi; b_as = n_as; b_de = n_de;
    setmb(8'h04); idle(3);
    wr(12'h040, 32'h04); idle(3);
    check("R9 disabled no msi", n_msi - b_msi, 0);
    check("R9 disabled no assert", n_as - b_as, 0);
    check("R9 disabled no deassert", n_de - b_de, 0);

    cfg_intx_dis = 0;
    b_as = n_as; b_de = n_de;
    setmb(8'h04); idle(3);
    cfg_intx_dis = 1; idle(3);
    check("R10 assert before disable", n_as - b_as, 1);
    check("R10 deassert on disable", n_de - b_de, 1);
    wr(12'h040, 32'h04); idle(2);
    cfg_intx_dis = 0;
    b_msi = n_msi; b_de = n_de;
    setmb(8'h04); idle(3);
    cfg_msi_en = 1; idle(3);
    check("R10 deassert on msi enable", n_de - b_de, 1);
    check("R10 no msi without edge", n_msi - b_msi, 0);
    wr(12'h040, 32'h04); idle(3);
    cfg_msi_en = 0; idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule